// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Waveform Sequencer

This block produces the time-multiplexed drive pattern for a passive LCD panel with up to four common lines and sixty segment lines. It does not make voltages. For every output pin it gives a 2-bit code that picks one of four drive levels, and an analog level shifter outside the block turns the code into a voltage. The block scans the active commons one after another. Each segment takes its level from the bit that the output latch holds for the common being scanned. The drive polarity flips on every frame so that no DC builds up across the panel.

Time advances only on the cycles where the oscillator enable `osc_en` is high; each such cycle is one tick. The duty select fixes how many commons are scanned and also the bias. With 2 commons the bias is 1/2; with 3 or 4 commons it is 1/3. The divider select sets how many ticks each common stays selected. Three separate conditions blank the panel: reset, the blank pin, and a cleared display-on flag. Blanking changes only the outputs and leaves the frame timing running.

Several instances can run in step over a shared wired-OR sync line. The master pulls the line low at the start of each frame. A slave restarts its frame on a falling edge of the line, after that edge has passed through a two-flop synchroniser.

Top module: `lcdw_sequencer`

## Requirements
- R1: `duty_sel` 00 or 01 scans 2 commons, 10 scans 3 and 11 scans 4. Exactly one scanned common is selected at a time, in ascending order starting from common 0 after reset.
- R2: Each common stays selected for D = DIV_BASE·2^`div_sel` ticks, so a frame lasts D·N ticks, where N is the number of scanned commons.
- R3: Level codes are 0 = GND, 1 = V1, 2 = V2, 3 = VLCD. With 1/3 bias (`duty_sel[1]`=1), the levels are: selected common 3 in even frames and 0 in odd frames; unselected common 1 in even frames and 2 in odd frames; ON segment 0 in even frames and 3 in odd frames; OFF segment 2 in even frames and 1 in odd frames.
- R4: With 1/2 bias (`duty_sel[1]`=0), the selected common and the ON segment behave as in R3, and unselected commons and OFF segments both sit at code 1 in every frame.
- R5: While common c is selected, segment s is ON when `seg_data[c*NUM_SEG+s]` is 1. The code for segment s is `seg_lvl[2s+1:2s]` and the code for common c is `com_lvl[2c+1:2c]`.
- R6: The first frame after reset is even, and the parity flips at every frame boundary.
- R7: Commons at or above N are never selected. They always carry the unselected-common level.
- R8: While reset is asserted, or `blank_n` is 0, or `lcd_on` is 0, every common and segment code is 3. Frame timing continues unchanged during blanking.
- R9: In master mode (`slave`=0), `sync_pull_n` is 0 during exactly the first tick of every frame and 1 at all other times. It is 1 while reset is asserted.
- R10: In slave mode, `sync_pull_n` stays 1. A falling edge on `sync_in_n`, after the two-flop synchroniser, restarts the frame at common 0 with its first tick and flips the parity. In master mode `sync_in_n` has no effect.
- R11: A cycle with `osc_en` low and no slave restart leaves the scan position and the parity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | Oscillator tick enable |
| duty_sel | input | 2 | Number of scanned commons; bit 1 also selects 1/3 bias |
| div_sel | input | 2 | Slot length divider, DIV_BASE shifted left by this value |
| lcd_on | input | 1 | Display-on flag; 0 blanks the panel |
| blank_n | input | 1 | Blank pin; 0 blanks the panel |
| slave | input | 1 | 1 = follow the sync line, 0 = drive it |
| sync_in_n | input | 1 | Sampled level of the shared sync line |
| seg_data | input | 4*NUM_SEG | Output latch contents, one row per common |
| com_lvl | output | 8 | Level codes of the four commons |
| seg_lvl | output | 2*NUM_SEG | Level codes of the segments |
| sync_pull_n | output | 1 | Open-drain pull-down request for the sync line (0 = pull low) |

## Verification
The bench sweeps all sixteen duty and divider settings over two full frames each. It compares every common and segment code tick by tick against an arithmetic model of slot, frame and parity. An off-by-one in the slot or frame wrap shows up there as a code that shifts a tick early or late. A swapped bias table, or an unused common that gets selected, gives a wrong code in a 2-common or 3-common setting. Idle ticks and blank windows are inserted in the middle of frames. A design that lets blanking or a missing tick move the counters loses phase for the rest of the frame. The slave restart is checked for position and for the parity flip. The master case checks that `sync_in_n` has no effect.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  // Four commons are addressable by the 2-bit duty selector.
  localparam int NUM_COM = 4;
  localparam int COM_W   = 2;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_V1   = 2'd1,
    LVL_V2   = 2'd2,
    LVL_VLCD = 2'd3
  } lvl_e;

  // Index of the last scanned common for a duty selector value.
  function automatic logic [COM_W-1:0] last_com(input logic [1:0] duty_sel);
    case (duty_sel)
      2'b10:   return 2'd2;
      2'b11:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  function automatic lvl_e com_code(input logic sel, input logic odd, input logic third);
    if (sel)    return odd ? LVL_GND : LVL_VLCD;
    if (!third) return LVL_V1;
    return odd ? LVL_V2 : LVL_V1;
  endfunction

  function automatic lvl_e seg_code(input logic on, input logic odd, input logic third);
    if (on)     return odd ? LVL_VLCD : LVL_GND;
    if (!third) return LVL_V1;
    return odd ? LVL_V1 : LVL_V2;
  endfunction

endpackage

// File: rtl/lcdw_rst_sync.sv
module lcdw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/lcdw_timebase.sv
module lcdw_timebase import lcdw_pkg::*; #(
  parameter int DIV_BASE = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [1:0]       duty_sel,
  input  logic [1:0]       div_sel,
  input  logic             slave,
  input  logic             sync_in_n,
  output logic [COM_W-1:0] com_idx,
  output logic             odd_frame,
  output logic             sync_pull_n
);
  localparam int SLOT_W = $clog2(DIV_BASE * 8);

  logic [SLOT_W-1:0] slot_q, slot_d, slot_last;
  logic [COM_W-1:0]  com_q, com_d, com_last;
  logic              odd_q, odd_d;
  logic              meta_q, stab_q, hist_q;
  logic              pull_q, pull_d;
  logic              restart, slot_end, com_end;

  // next-state
  always_comb begin
    slot_last = SLOT_W'((DIV_BASE << div_sel) - 1);
    com_last  = last_com(duty_sel);
    restart   = slave && !stab_q && hist_q;
    slot_end  = (slot_q >= slot_last);
    com_end   = (com_q >= com_last);
    slot_d    = slot_q;
    com_d     = com_q;
    odd_d     = odd_q;
    if (restart) begin
      slot_d = '0;
      com_d  = '0;
      odd_d  = !odd_q;
    end else if (osc_en) begin
      if (slot_end) begin
        slot_d = '0;
        if (com_end) begin
          com_d = '0;
          odd_d = !odd_q;
        end else begin
          com_d = com_q + 1'b1;
        end
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
    pull_d = !(!slave && (slot_d == '0) && (com_d == '0));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      com_q  <= '0;
      odd_q  <= 1'b0;
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      hist_q <= 1'b1;
      pull_q <= 1'b1;
    end else begin
      slot_q <= slot_d;
      com_q  <= com_d;
      odd_q  <= odd_d;
      meta_q <= sync_in_n;
      stab_q <= meta_q;
      hist_q <= stab_q;
      pull_q <= pull_d;
    end
  end

  assign com_idx     = com_q;
  assign odd_frame   = odd_q;
  assign sync_pull_n = pull_q;

  assert_frame_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !restart && slot_end && com_end) |=> (odd_q != $past(odd_q)));

  assert_slave_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (slot_q == '0 && com_q == '0));

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull_q && osc_en && !restart) |=> pull_q);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !restart) |=> ($stable(slot_q) && $stable(com_q) && $stable(odd_q)));
endmodule

// File: rtl/lcdw_level_map.sv
module lcdw_level_map import lcdw_pkg::*; #(
  parameter int NUM_SEG = 60
) (
  input  logic [COM_W-1:0]           com_idx,
  input  logic                       odd_frame,
  input  logic                       third,
  input  logic                       blank,
  input  logic [NUM_COM*NUM_SEG-1:0] seg_data,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  logic [NUM_SEG-1:0] row;

  always_comb row = seg_data[com_idx*NUM_SEG +: NUM_SEG];

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (blank) com_lvl[2*c +: 2] = LVL_VLCD;
      else       com_lvl[2*c +: 2] = com_code(com_idx == COM_W'(c), odd_frame, third);
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_comb begin
      if (blank) seg_lvl[2*s +: 2] = LVL_VLCD;
      else       seg_lvl[2*s +: 2] = seg_code(row[s], odd_frame, third);
    end
  end
endmodule

// File: rtl/lcdw_sequencer.sv
module lcdw_sequencer import lcdw_pkg::*; #(
  parameter int NUM_SEG  = 60,
  parameter int DIV_BASE = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_en,
  input  logic [1:0]                 duty_sel,
  input  logic [1:0]                 div_sel,
  input  logic                       lcd_on,
  input  logic                       blank_n,
  input  logic                       slave,
  input  logic                       sync_in_n,
  input  logic [NUM_COM*NUM_SEG-1:0] seg_data,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl,
  output logic                       sync_pull_n
);
  logic             rst_sync_n;
  logic [COM_W-1:0] com_idx;
  logic             odd_frame;
  logic             blank;

  lcdw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcdw_timebase #(.DIV_BASE(DIV_BASE)) u_time (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .osc_en      (osc_en),
    .duty_sel    (duty_sel),
    .div_sel     (div_sel),
    .slave       (slave),
    .sync_in_n   (sync_in_n),
    .com_idx     (com_idx),
    .odd_frame   (odd_frame),
    .sync_pull_n (sync_pull_n)
  );

  assign blank = !rst_sync_n || !blank_n || !lcd_on;

  lcdw_level_map #(.NUM_SEG(NUM_SEG)) u_map (
    .com_idx   (com_idx),
    .odd_frame (odd_frame),
    .third     (duty_sel[1]),
    .blank     (blank),
    .seg_data  (seg_data),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl)
  );

  // Observation helpers for the checks below.
  logic [NUM_COM-1:0] extreme_vec;
  logic [1:0]         sel_code;
  logic [NUM_SEG-1:0] cur_row;

  always_comb begin
    for (int c = 0; c < NUM_COM; c++)
      extreme_vec[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
    sel_code = com_lvl[com_idx*2 +: 2];
    cur_row  = seg_data[com_idx*NUM_SEG +: NUM_SEG];
  end

  assert_blank_all_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!blank_n || !lcd_on) |-> ((&com_lvl) && (&seg_lvl)));

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !blank |-> ($countones(extreme_vec) == 1));

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_chk
    assert_on_opposite_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!blank && cur_row[s]) |-> (seg_lvl[2*s +: 2] == ~sel_code));
  end
endmodule

// File: tb/lcdw_sequencer_tb_top.sv
module lcdw_sequencer_tb_top;
  localparam int NS = 60;
  localparam int DB = 4;

  logic            clk = 1'b0;
  logic            rst_n, osc_en, lcd_on, blank_n, slave, sync_in_n;
  logic [1:0]      duty_sel, div_sel;
  logic [4*NS-1:0] seg_data;
  logic [7:0]      com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic            sync_pull_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lcdw_sequencer #(.NUM_SEG(NS), .DIV_BASE(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .duty_sel(duty_sel),
    .div_sel(div_sel), .lcd_on(lcd_on), .blank_n(blank_n), .slave(slave),
    .sync_in_n(sync_in_n), .seg_data(seg_data), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .sync_pull_n(sync_pull_n)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // Expected outputs for tick k of the model, parity base pb.
  task automatic check_state(input int k, input int pb, input string tag);
    int n, d, fr, cm;
    bit odd, third, blk;
    logic [7:0]      ec;
    logic [2*NS-1:0] es;
    logic            ey;
    n     = (duty_sel == 2'b10) ? 3 : (duty_sel == 2'b11) ? 4 : 2;
    d     = DB << div_sel;
    fr    = k / (d * n);
    cm    = (k % (d * n)) / d;
    odd   = bit'(pb) ^ bit'(fr & 1);
    third = duty_sel[1];
    blk   = !blank_n || !lcd_on;
    for (int c = 0; c < 4; c++) begin
      if (blk)          ec[2*c +: 2] = 2'd3;
      else if (c == cm) ec[2*c +: 2] = odd ? 2'd0 : 2'd3;
      else if (!third)  ec[2*c +: 2] = 2'd1;
      else              ec[2*c +: 2] = odd ? 2'd2 : 2'd1;
    end
    for (int s = 0; s < NS; s++) begin
      if (blk)                  es[2*s +: 2] = 2'd3;
      else if (seg_data[cm*NS + s]) es[2*s +: 2] = odd ? 2'd3 : 2'd0;
      else if (!third)          es[2*s +: 2] = 2'd1;
      else                      es[2*s +: 2] = odd ? 2'd1 : 2'd2;
    end
    ey = slave ? 1'b1 : ((k % (d * n)) != 0);
    n_chk += 3;
    if (com_lvl !== ec) begin
      n_fail++;
      $display("FAIL %s %s tick %0d com_lvl actual %h expected %h", tag,
               third ? "R3" : "R4", k, com_lvl, ec);
    end
    if (seg_lvl !== es) begin
      n_fail++;
      $display("FAIL %s %s tick %0d seg_lvl actual %h expected %h", tag,
               third ? "R3" : "R4", k, seg_lvl, es);
    end
    if (sync_pull_n !== ey) begin
      n_fail++;
      $display("FAIL %s R9 tick %0d sync_pull_n actual %b expected %b", tag, k,
               sync_pull_n, ey);
    end
  endtask

  task automatic do_reset(input logic [1:0] ds, input logic [1:0] vs, input logic sl);
    @(negedge clk);
    rst_n = 1'b0; osc_en = 1'b0; lcd_on = 1'b1; blank_n = 1'b1;
    sync_in_n = 1'b1; slave = sl; duty_sel = ds; div_sel = vs;
    for (int i = 0; i < 4*NS; i++) seg_data[i] = 1'($urandom());
    @(negedge clk); @(negedge clk); #1;
    n_chk += 2;
    if (!((&com_lvl) && (&seg_lvl))) begin
      n_fail++;
      $display("FAIL R8 reset blank actual %h/%h expected all 3", com_lvl, seg_lvl);
    end
    if (sync_pull_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 reset sync_pull_n actual %b expected 1", sync_pull_n);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    check_state(0, 0, "R6 R1 after-reset");
  endtask

  // Advances from tick k0 (already checked) to tick k1.
  task automatic run_ticks(input int k0, input int k1, input int pb, input bit inject);
    osc_en = 1'b1;
    for (int k = k0 + 1; k <= k1; k++) begin
      @(negedge clk);
      blank_n = !(inject && k >= 5 && k <= 8);
      lcd_on  = !(inject && k >= 12 && k <= 14);
      #1;
      check_state(k, pb, (!blank_n || !lcd_on) ? "R8 R2" : "R1 R2 R5 R6 R7");
      if (inject && (k % 7 == 3)) begin
        osc_en = 1'b0;
        @(negedge clk); #1;
        check_state(k, pb, "R11 idle");
        osc_en = 1'b1;
      end
    end
    osc_en  = 1'b0;
    blank_n = 1'b1;
    lcd_on  = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int nb;
    rst_n = 1'b0; osc_en = 1'b0; lcd_on = 1'b1; blank_n = 1'b1;
    slave = 1'b0; sync_in_n = 1'b1; duty_sel = 2'b00; div_sel = 2'b00;
    seg_data = '0;

    // full sweep of duty and divider settings, master mode
    for (int ds = 0; ds < 4; ds++) begin
      for (int vs = 0; vs < 4; vs++) begin
        int n;
        n = (ds == 2) ? 3 : (ds == 3) ? 4 : 2;
        do_reset(2'(ds), 2'(vs), 1'b0);
        run_ticks(0, 2 * (DB << vs) * n + 3, 0, 1'b1);
      end
    end

    // R10 slave restart on synchronised falling edge
    do_reset(2'b11, 2'b00, 1'b1);
    run_ticks(0, 21, 0, 1'b0);
    @(negedge clk); sync_in_n = 1'b0;
    repeat (6) @(negedge clk);
    sync_in_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    nb = ((21 / 16) & 1) ^ 1;
    check_state(0, nb, "R10 slave restart");
    run_ticks(0, 40, nb, 1'b0);

    // R10 master ignores the sync line
    do_reset(2'b11, 2'b00, 1'b0);
    run_ticks(0, 5, 0, 1'b0);
    @(negedge clk); sync_in_n = 1'b0;
    repeat (6) @(negedge clk);
    sync_in_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    check_state(5, 0, "R10 master ignores sync");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule